// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block gives software control of up to a couple of hundred general-purpose pads through a small register bus with 64-bit data. The lines are grouped into banks of 64. Each bank has three registers: one that returns the pad levels seen at the input, one that raises output bits, and one that lowers them. Software never writes the output latch directly. A write of ones to the raise register or to the lower register changes only the selected lines, so concurrent users of one bank cannot overwrite each other's bits.

Every line has its own configuration word. It holds an output enable, a polarity invert that acts on both directions, an open-drain selector and a pin-function selector. In open-drain mode the line pulls low and never drives high. When the pin-function selector is not zero, an alternate function owns the pad and the output latch is bypassed. A constant register reports the line count and the first interrupt vector number that the line interrupts are allocated from.

Reads return data one cycle after the read strobe, and the read data holds until the next read. The pad outputs follow the latch and configuration state directly, with no added register stage.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every output latch and every configuration word is zero. All pad_oe and pad_out bits are 0 (while alt inputs are 0), and the raise and configuration registers read 0.
- R2: A write to the raise register of bank b (byte address 0x8 + b*0x1400) sets the latch bit for each 1 in the write data. Bits written as 0 keep their value.
- R3: A write to the lower register of bank b (address 0x10 + b*0x1400) clears the latch bit for each 1 in the write data. Bits written as 0 keep their value.
- R4: A read of the raise register returns the bank's latch contents with no inversion. A read of the lower register returns 0.
- R5: A read of the input register of bank b (address 0x0 + b*0x1400) returns, for each line, the pad_in level after a two-flop synchronizer XORed with the line's invert bit. A pad change becomes visible to a read issued two cycles later.
- R6: The configuration word of line n is at 0x400 + 8*n. Bit 0 is output enable, bit 1 is invert, bit 12 is open-drain and bits 25:16 are the pin-function selector. All other bits read as 0 and ignore writes.
- R7: In push-pull mode (bit 12 = 0, function 0), pad_oe equals the output enable and pad_out equals latch XOR invert.
- R8: In open-drain mode (bit 12 = 1, function 0), pad_out is 0 and pad_oe is 1 only when the output enable is set and latch XOR invert is 0.
- R9: When the function selector is nonzero, pad_out and pad_oe follow alt_out and alt_oe for that line. The latch stays writable through the raise and lower registers.
- R10: The constant register at 0x90 reads with the line count in bits 7:0, the base interrupt vector in bits 15:8 and 0 elsewhere. Line i uses vector base + 2*i.
- R11: reg_rdata changes only in the cycle after a read strobe. A read of an unmapped address, or of a configuration slot at or beyond the line count, returns 0. Writes to such addresses change no state.
- R12: The second bank uses the same register layout offset by 0x1400 and acts independently of the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after reg_rd |
| pad_in | input | NUM_LINES | Pad input levels, asynchronous |
| pad_out | output | NUM_LINES | Pad output data |
| pad_oe | output | NUM_LINES | Pad output enable |
| alt_out | input | NUM_LINES | Alternate-function output data |
| alt_oe | input | NUM_LINES | Alternate-function output enable |

## Verification
A write takes effect at the clock edge that samples it, so the latch readback and the pad outputs are compared at the falling edge that follows. Read data is due one edge after the read strobe. The driver task queues the expected word when it raises the strobe, and the monitor takes it off the queue at the next falling edge that follows a sampled strobe. Pad input changes pass through two synchronizer flops, so the bench waits at least two cycles before it reads the new level. It also checks that a read issued at once still returns the old level. The hold of reg_rdata between reads is checked a few idle cycles after the last read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int BANK_W = 64;
  localparam int FN_W   = 10;

  localparam logic [15:0] OFF_DAT     = 16'h0000;
  localparam logic [15:0] OFF_SET     = 16'h0008;
  localparam logic [15:0] OFF_CLR     = 16'h0010;
  localparam logic [15:0] OFF_CONST   = 16'h0090;
  localparam logic [15:0] OFF_CFG     = 16'h0400;
  localparam logic [15:0] BANK_STRIDE = 16'h1400;

  localparam int CFG_OE_BIT  = 0;
  localparam int CFG_INV_BIT = 1;
  localparam int CFG_OD_BIT  = 12;
  localparam int CFG_FN_LSB  = 16;

  typedef struct packed {
    logic [FN_W-1:0] fn;
    logic            od;
    logic            inv;
    logic            oe;
  } line_cfg_t;

  function automatic line_cfg_t cfg_from_word(input logic [63:0] w);
    line_cfg_t c;
    c.oe  = w[CFG_OE_BIT];
    c.inv = w[CFG_INV_BIT];
    c.od  = w[CFG_OD_BIT];
    c.fn  = w[CFG_FN_LSB +: FN_W];
    return c;
  endfunction

  function automatic logic [63:0] cfg_to_word(input line_cfg_t c);
    logic [63:0] w;
    w = '0;
    w[CFG_OE_BIT]            = c.oe;
    w[CFG_INV_BIT]           = c.inv;
    w[CFG_OD_BIT]            = c.od;
    w[CFG_FN_LSB +: FN_W]    = c.fn;
    return w;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank #(
  parameter int          W         = 64,
  parameter logic [63:0] LANE_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q
);

  logic [W-1:0] latch_d;
  logic         latch_en;
  logic [W-1:0] lanes;

  assign lanes    = LANE_MASK[W-1:0];
  assign latch_en = set_we | clr_we;

  always_comb begin
    latch_d = latch_q;
    if (set_we) begin
      latch_d = latch_q | (wdata & lanes);
    end else if (clr_we) begin
      latch_d = latch_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

endmodule

// File: rtl/gpio_cfg_array.sv
module gpio_cfg_array
  import gpio_port_pkg::*;
#(
  parameter int N  = 128,
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [LW-1:0]         wr_line,
  input  logic [63:0]           wdata,
  output line_cfg_t [N-1:0]     cfg_q
);

  line_cfg_t wr_cfg;

  assign wr_cfg = cfg_from_word(wdata);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic      line_we;
    line_cfg_t line_d;

    assign line_we = wr_en && (wr_line == LW'(i));

    always_comb begin
      line_d = cfg_q[i];
      if (line_we) begin
        line_d = wr_cfg;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (line_we) begin
        cfg_q[i] <= line_d;
      end
    end
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter int N = 128
) (
  input  line_cfg_t [N-1:0] cfg,
  input  logic [N-1:0]      latch,
  input  logic [N-1:0]      alt_out,
  input  logic [N-1:0]      alt_oe,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe
);

  for (genvar i = 0; i < N; i++) begin : g_pad
    logic eff;
    logic owned;

    assign eff   = latch[i] ^ cfg[i].inv;
    assign owned = (cfg[i].fn == '0);

    always_comb begin
      if (!owned) begin
        pad_out[i] = alt_out[i];
        pad_oe[i]  = alt_oe[i];
      end else if (cfg[i].od) begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = cfg[i].oe & ~eff;
      end else begin
        pad_out[i] = eff;
        pad_oe[i]  = cfg[i].oe;
      end
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int          NUM_LINES = 128,
  parameter int          ADDR_W    = 16,
  parameter logic [7:0]  BASE_VEC  = 8'h30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [63:0]          reg_wdata,
  output logic [63:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  input  logic [NUM_LINES-1:0] alt_out,
  input  logic [NUM_LINES-1:0] alt_oe
);

  localparam int NB = (NUM_LINES + BANK_W - 1) / BANK_W;
  localparam int BW = NB * BANK_W;
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(8 * NUM_LINES);
  localparam logic [63:0] CONST_WORD = {48'h0, BASE_VEC, 8'(NUM_LINES)};

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // address decode
  logic [NB-1:0]     hit_dat, hit_set, hit_clr;
  logic              hit_const, hit_cfg;
  logic [ADDR_W-1:0] cfg_off;
  logic [LW-1:0]     cfg_line;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(b * BANK_STRIDE);
    assign hit_dat[b] = (reg_addr == BASE + ADDR_W'(OFF_DAT));
    assign hit_set[b] = (reg_addr == BASE + ADDR_W'(OFF_SET));
    assign hit_clr[b] = (reg_addr == BASE + ADDR_W'(OFF_CLR));
  end

  assign hit_const = (reg_addr == ADDR_W'(OFF_CONST));
  assign cfg_off   = reg_addr - CFG_BASE;
  assign hit_cfg   = (reg_addr >= CFG_BASE) && (cfg_off < CFG_SPAN) &&
                     (reg_addr[2:0] == 3'b000);
  assign cfg_line  = cfg_off[LW+2:3];

  // output latches, one bank per 64 lines
  logic [BW-1:0] out_latch;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int LANES = ((NUM_LINES - b * BANK_W) > BANK_W) ?
                           BANK_W : (NUM_LINES - b * BANK_W);
    localparam logic [63:0] MASK = (LANES >= 64) ? '1 :
                                   ((64'd1 << LANES) - 64'd1);

    gpio_out_bank #(
      .W         (BANK_W),
      .LANE_MASK (MASK)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_we  (reg_wr && hit_set[b]),
      .clr_we  (reg_wr && hit_clr[b]),
      .wdata   (reg_wdata),
      .latch_q (out_latch[b*BANK_W +: BANK_W])
    );
  end

  // per-line configuration
  line_cfg_t [NUM_LINES-1:0] cfg_q;
  logic [NUM_LINES-1:0]      inv_v, od_v, fn_v;

  gpio_cfg_array #(
    .N  (NUM_LINES),
    .LW (LW)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr && hit_cfg),
    .wr_line (cfg_line),
    .wdata   (reg_wdata),
    .cfg_q   (cfg_q)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_fld
    assign inv_v[i] = cfg_q[i].inv;
    assign od_v[i]  = cfg_q[i].od;
    assign fn_v[i]  = |cfg_q[i].fn;
  end

  // input path
  logic [NUM_LINES-1:0] pad_sync;
  logic [BW-1:0]        in_view;

  gpio_sync2 #(
    .W (NUM_LINES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  always_comb begin
    in_view = '0;
    in_view[NUM_LINES-1:0] = pad_sync ^ inv_v;
  end

  // pad drive
  gpio_pad_drive #(
    .N (NUM_LINES)
  ) u_pad (
    .cfg     (cfg_q),
    .latch   (out_latch[NUM_LINES-1:0]),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  // read path
  logic [63:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (hit_const) begin
      rdata_d = CONST_WORD;
    end
    if (hit_cfg) begin
      rdata_d = cfg_to_word(cfg_q[cfg_line]);
    end
    for (int b = 0; b < NB; b++) begin
      if (hit_dat[b]) begin
        rdata_d = in_view[b*BANK_W +: BANK_W];
      end
      if (hit_set[b]) begin
        rdata_d = out_latch[b*BANK_W +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int          NUM_LINES = 128,
  parameter int          ADDR_W    = 16,
  parameter logic [7:0]  BASE_VEC  = 8'h30,
  parameter int          BW        = 128
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [63:0]          reg_wdata,
  input logic [63:0]          reg_rdata,
  input logic [NUM_LINES-1:0] pad_out,
  input logic [BW-1:0]        out_latch,
  input logic [NUM_LINES-1:0] od_v,
  input logic [NUM_LINES-1:0] fn_v
);

  localparam int NB = BW / BANK_W;

  for (genvar b = 0; b < NB; b++) begin : g_bank_chk
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(b * BANK_STRIDE + OFF_SET);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(b * BANK_STRIDE + OFF_CLR);
    localparam int LANES = ((NUM_LINES - b * BANK_W) > BANK_W) ?
                           BANK_W : (NUM_LINES - b * BANK_W);
    localparam logic [63:0] MASK = (LANES >= 64) ? '1 :
                                   ((64'd1 << LANES) - 64'd1);

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == SET_A) |=>
        ((out_latch[b*BANK_W +: BANK_W] & $past(reg_wdata & MASK)) ==
         $past(reg_wdata & MASK)));

    // R2
    set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == SET_A) |=>
        ((out_latch[b*BANK_W +: BANK_W] & ~$past(reg_wdata)) ==
         ($past(out_latch[b*BANK_W +: BANK_W]) & ~$past(reg_wdata))));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == CLR_A) |=>
        ((out_latch[b*BANK_W +: BANK_W] & $past(reg_wdata)) == 64'h0));
  end

  // R8
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & od_v & ~fn_v) == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R10
  const_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(OFF_CONST)) |=>
      (reg_rdata == {48'h0, BASE_VEC, 8'(NUM_LINES)}));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W),
  .BASE_VEC  (BASE_VEC),
  .BW        (BW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pad_out   (pad_out),
  .out_latch (out_latch),
  .od_v      (od_v),
  .fn_v      (fn_v)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;

  localparam int         N   = 128;
  localparam int         AW  = 16;
  localparam logic [7:0] VEC = 8'h30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [AW-1:0] reg_addr;
  logic [63:0]   reg_wdata, reg_rdata;
  logic [N-1:0]  pad_in, pad_out, pad_oe, alt_out, alt_oe;

  always #4 clk = ~clk;

  gpio_port_ctrl #(
    .NUM_LINES (N),
    .ADDR_W    (AW),
    .BASE_VEC  (VEC)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .alt_out   (alt_out),
    .alt_oe    (alt_oe)
  );

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: a strobe sampled at a rising edge has its data at the next falling edge
  always @(posedge clk) pend <= reg_rd;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R11: actual unexpected read expected none");
      end else begin
        check(tag_q.pop_front(), {64'h0, reg_rdata}, {64'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic wr_reg(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, input logic [63:0] e,
                        input string tag);
    @(negedge clk);
    reg_rd   = 1'b1;
    reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd   = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    pad_in = '0; alt_out = '0; alt_oe = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    rd_reg(16'h0008, 64'h0, "R1 bank0 latch");
    rd_reg(16'h1408, 64'h0, "R1 bank1 latch");
    rd_reg(16'h0428, 64'h0, "R1 cfg line5");

    // R10 constant word: count 128, base 0x30
    rd_reg(16'h0090, 64'h3080, "R10 const");

    // R2 / R3 / R4 raise and lower
    wr_reg(16'h0008, 64'hF0);
    rd_reg(16'h0008, 64'hF0, "R2 set");
    wr_reg(16'h0008, 64'h0F);
    rd_reg(16'h0008, 64'hFF, "R2 zero bits keep");
    wr_reg(16'h0010, 64'h30);
    rd_reg(16'h0008, 64'hCF, "R3 clear");
    rd_reg(16'h0010, 64'h0, "R4 clear reads zero");

    // R12 second bank
    wr_reg(16'h1408, 64'h8);
    rd_reg(16'h1408, 64'h8, "R12 bank1 set");
    rd_reg(16'h0008, 64'hCF, "R12 bank0 untouched");
    wr_reg(16'h1410, 64'h8);
    rd_reg(16'h1408, 64'h0, "R12 bank1 clear");

    // R7 push-pull on line 4 (latch 0)
    wr_reg(16'h0420, 64'h1);
    check("R7 oe line4", pad_oe[4], 1'b1);
    check("R7 out line4", pad_out[4], 1'b0);
    wr_reg(16'h0420, 64'h3);
    check("R7 inverted out line4", pad_out[4], 1'b1);
    rd_reg(16'h0420, 64'h3, "R6 cfg readback");
    wr_reg(16'h0420, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(16'h0420, 64'h0000_0000_03FF_1003, "R6 field mask");
    check("R9 fn owned out line4", pad_out[4], 1'b0);
    check("R9 fn owned oe line4", pad_oe[4], 1'b0);
    wr_reg(16'h0420, 64'h0);
    check("R7 disabled line4", pad_oe[4], 1'b0);

    // R8 open-drain on line 0 (latch 1)
    wr_reg(16'h0400, 64'h1001);
    check("R8 high released oe", pad_oe[0], 1'b0);
    check("R8 high released out", pad_out[0], 1'b0);
    wr_reg(16'h0010, 64'h1);
    check("R8 low pulls oe", pad_oe[0], 1'b1);
    check("R8 low pulls out", pad_out[0], 1'b0);
    wr_reg(16'h0400, 64'h1003);
    check("R8 inverted release", pad_oe[0], 1'b0);
    wr_reg(16'h0400, 64'h2);

    // R9 alternate function on line 7 (latch 1)
    alt_out = '1;
    wr_reg(16'h0438, 64'h1_0001);
    check("R9 alt out", pad_out[7], 1'b1);
    check("R9 alt oe", pad_oe[7], 1'b0);
    alt_out[7] = 1'b0;
    @(negedge clk);
    check("R9 alt out follows", pad_out[7], 1'b0);
    alt_oe = '1;
    @(negedge clk);
    check("R9 alt oe follows", pad_oe[7], 1'b1);
    wr_reg(16'h0008, 64'h80);
    rd_reg(16'h0008, 64'hCE, "R9 latch writable");

    // R5 input path, inverted on lines 0 and 70
    wr_reg(16'h0630, 64'h2);
    pad_in = {64'hA5A5_0000_FFFF_1234, 64'h0123_4567_89AB_CDEF};
    repeat (3) @(negedge clk);
    rd_reg(16'h0000, 64'h0123_4567_89AB_CDEE, "R5 bank0 input");
    rd_reg(16'h1400, 64'hA5A5_0000_FFFF_1274, "R5 bank1 input");
    pad_in[63:0] = '0;
    rd_reg(16'h0000, 64'h0123_4567_89AB_CDEE, "R5 sync delay");
    repeat (3) @(negedge clk);
    rd_reg(16'h0000, 64'h1, "R5 new level");

    // R11 unmapped addresses
    wr_reg(16'h0018, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(16'h0018, 64'h0, "R11 unmapped read");
    rd_reg(16'h0800, 64'h0, "R11 cfg beyond lines");
    rd_reg(16'h0008, 64'hCE, "R11 write no effect");
    repeat (3) @(negedge clk);
    check("R11 rdata holds", {64'h0, reg_rdata}, {64'h0, 64'hCE});
    check("R11 queue drained", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule